// File: doc/BRIEF.md
# Cyclic Multi-Modulus Sequence Counter

This block is a synchronous counter. Its value output steps through a repeating pattern of three runs of different lengths. The first run counts 0 to 7, the second counts 0 to 5 and the third counts 0 to 3. The pattern then starts again with the first run. A separate two-bit phase register records which run is active. The phase register decides the point where the value wraps, so the modulus of the value counter follows the order 8, 6, 4.

Every flop shares one clock. Decoded outputs therefore carry no ripple glitches. The terminal value of the active run is detected in the same cycle in which it appears, so the wrap to zero happens on the next enabled edge without any asynchronous clear. Two combinational pulses flag the last cycle of each run and the last cycle of the whole pattern. A parent block can use them to sequence other logic. If the phase register ever holds the unused code 3, the next enabled edge returns both the phase and the value to zero.

Top module: `seq_mod_counter`

## Requirements
- R1: While rst is high at a rising clock edge, count and phase both become 0 at that edge, whatever en is.
- R2: In phase 0, each enabled edge raises count by one from 0 up to 7, and the edge taken at 7 sets count to 0 and phase to 1.
- R3: In phase 1, count rises by one from 0 up to 5, and the enabled edge taken at 5 sets count to 0 and phase to 2.
- R4: In phase 2, count rises by one from 0 up to 3, and the enabled edge taken at 3 sets count to 0 and phase to 0.
- R5: Phase moves only on an enabled edge taken at the terminal value of the active run, and after any reset it never holds the value 3.
- R6: When en is low and rst is low, count and phase keep their values across the edge, and run_end and pattern_end stay low.
- R7: run_end is high exactly when en is high and count equals the terminal value of the active run: 7 in phase 0, 5 in phase 1, 3 in phase 2.
- R8: pattern_end is high exactly when en is high, phase is 2 and count is 3, so it recurs every 18 enabled cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| count | output | 3 | Current value within the active run |
| phase | output | 2 | Index of the active run: 0, 1 or 2 |
| run_end | output | 1 | High on the last enabled cycle of any run |
| pattern_end | output | 1 | High on the last enabled cycle of the third run |

## Verification
The bench aims at the three wrap points. A design that decodes a terminal value without gating it by phase would wrap early: it would end the first run at 3 or 5, or it would pass 5 in the second run. A design that decodes the successor value would show 8, 6 or 4 for one cycle. Long stretches with en low are placed right on terminal values, which exposes a design that lets the pulses or the phase move while it is stalled. Resets are scattered at random in the middle of runs to show that the phase clears along with the value.

// File: rtl/seq_mod_counter.sv
module seq_mod_counter #(
  parameter int VAL_W = 3,
  parameter int PH_W  = 2,
  parameter logic [VAL_W-1:0] TERM0 = 3'd7,
  parameter logic [VAL_W-1:0] TERM1 = 3'd5,
  parameter logic [VAL_W-1:0] TERM2 = 3'd3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [VAL_W-1:0] count,
  output logic [PH_W-1:0]  phase,
  output logic             run_end,
  output logic             pattern_end
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2);

  logic [VAL_W-1:0] term;
  logic             ph_bad;
  logic             at_term;

  always_comb begin
    case (phase)
      PH_W'(0): term = TERM0;
      PH_W'(1): term = TERM1;
      default:  term = TERM2;
    endcase
  end

  assign ph_bad      = (phase > PH_LAST);
  assign at_term     = !ph_bad && (count == term);
  assign run_end     = en && at_term;
  assign pattern_end = run_end && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      phase <= '0;
    end else if (en) begin
      if (ph_bad) begin
        count <= '0;
        phase <= '0;
      end else if (at_term) begin
        count <= '0;
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/seq_mod_counter_chk.sv
module seq_mod_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] count,
  input logic [1:0] phase,
  input logic       run_end,
  input logic       pattern_end
);

  p_reset_r1: assert property (@(posedge clk) rst |=> (count == 3'd0 && phase == 2'd0));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !run_end && phase != 2'd3) |=> (count == $past(count) + 3'd1 && phase == $past(phase)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (en && phase == 2'd1 && count == 3'd5) |=> (count == 3'd0 && phase == 2'd2));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (en && phase == 2'd2 && count == 3'd3) |=> (count == 3'd0 && phase == 2'd0));

  p_phase_legal_r5: assert property (@(posedge clk) disable iff (rst) phase != 2'd3);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(count) && $stable(phase)));

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!run_end && !pattern_end));

  p_end_r7: assert property (@(posedge clk) disable iff (rst)
    (en && phase == 2'd0 && count == 3'd7) |-> run_end);

  p_pattern_r8: assert property (@(posedge clk) disable iff (rst)
    pattern_end |-> (run_end && phase == 2'd2 && count == 3'd3));

endmodule

bind seq_mod_counter seq_mod_counter_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .count(count), .phase(phase),
  .run_end(run_end), .pattern_end(pattern_end)
);

// File: tb/seq_mod_counter_test.sv
`timescale 1ns/1ps
module seq_mod_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2:0] count;
  logic [1:0] phase;
  logic run_end, pattern_end;

  int total = 0;
  int bad   = 0;
  int m_cnt = 0;
  int m_ph  = 0;
  int en_cycles = 0;
  int last_pat  = -1;
  bit done = 0;

  always #4 clk = ~clk;

  seq_mod_counter uut (
    .clk(clk), .rst(rst), .en(en), .count(count), .phase(phase),
    .run_end(run_end), .pattern_end(pattern_end)
  );

  function automatic int term_of(int ph);
    return (ph == 0) ? 7 : (ph == 1) ? 5 : 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_cnt = 0; m_ph = 0; en_cycles = 0; last_pat = -1;
    end else if (en) begin
      en_cycles++;
      if (m_cnt == term_of(m_ph)) begin
        m_cnt = 0;
        m_ph = (m_ph == 2) ? 0 : m_ph + 1;
      end else m_cnt++;
    end
  endtask

  task automatic cycle(bit r, bit e, string req);
    int exp_re, exp_pe;
    @(negedge clk);
    rst = r; en = e;
    #1;
    exp_re = (e && m_cnt == term_of(m_ph)) ? 1 : 0;
    exp_pe = (exp_re && m_ph == 2) ? 1 : 0;
    chk({req, " count"}, count, m_cnt);
    chk({req, " phase"}, phase, m_ph);
    chk("R7 run_end", run_end, exp_re);
    chk("R8 pattern_end", pattern_end, exp_pe);
    if (!e) chk("R6 no pulse when stalled", run_end | pattern_end, 0);
    if (pattern_end && !r) begin
      if (last_pat >= 0) chk("R8 period", en_cycles + 1 - last_pat, 18);
      last_pat = en_cycles + 1;
    end
    model_step();
  endtask

  initial begin
    #1_600_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cycle(1, 0, "R1");
    cycle(1, 1, "R1");
    cycle(0, 0, "R1 reset state");
    for (int i = 0; i < 40; i++) cycle(0, 1, "R2 R3 R4");
    for (int i = 0; i < 60; i++) begin
      if (m_cnt == term_of(m_ph)) cycle(0, 0, "R6 stall at terminal");
      else cycle(0, 1, "R5");
    end
    cycle(0, 1, "R3");
    for (int i = 0; i < 3; i++) cycle(0, 0, "R6");
    for (int i = 0; i < 4000; i++) begin
      bit r, e;
      r = ($urandom % 97) == 0;
      e = ($urandom % 4) != 0;
      cycle(r, e, "R5 random");
    end
    for (int i = 0; i < 5; i++) cycle(1, 1, "R1");
    for (int i = 0; i < 72; i++) cycle(0, 1, "R8 full patterns");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule